// File: doc/BRIEF.md
# Register Control Word Write Decoder

This block lives in the registered command path of a memory-module register buffer. Every clock it samples the chip selects, address, bank address, command strobes, clock enables and on-die-termination inputs and normally presents a one-cycle-delayed copy of them on its outputs. When the chip-select pattern marks a control word access, it does not forward the command. Instead it holds the registered outputs, drives all select outputs high, and may update one of sixteen 4-bit configuration words.

The access pattern depends on a quad-select mode input. A write goes through only when address/command parity is even, the upper address bits are clear and at least one clock enable is high. A parity mismatch on an access raises a one-cycle active-low error flag and leaves the configuration unchanged. The sixteen words are presented side by side on one flat output bus. The meaning of each word is up to the surrounding logic.

Top module: `ctlword_dec`

## Requirements
- R1: With `quad_mode` low, an access is recognised when `cs_n[0]` and `cs_n[1]` are both low (selects are active low); the states of `cs_n[3:2]` do not matter. With `quad_mode` low and `cs_n[1:0]` not both low, no access takes place.
- R2: With `quad_mode` high, an access is recognised when `cs_n` is 4'b0011 or 4'b0000. Any other pattern with fewer than three selects low is not an access.
- R3: With `quad_mode` high, a pattern with exactly three selects low is not an access. The command passes through as a normal cycle and no configuration word changes.
- R4: The word index is {bank[2], addr[2], addr[1], addr[0]} and the written value is {bank[1], bank[0], addr[4], addr[3]}. Word k appears on `cfg_words[4k+3:4k]` one clock after the access is sampled.
- R5: A write happens only if `addr[15:5]` is all zero and at least one bit of `cke` is high. Otherwise the access still freezes the outputs, but every configuration word keeps its value.
- R6: The levels of `ras_n`, `cas_n`, `we_n` and `odt` do not change whether an access is recognised or what value it writes. The strobes still count toward parity.
- R7: Parity is even over `addr[15:0]`, `bank[2:0]`, `ras_n`, `cas_n`, `we_n` and `par_in`. On an access whose XOR of these is 1, `err_n` is low in the following cycle only, and no word changes.
- R8: For the cycle after an access, `q_cs_n` is all ones and `q_addr`, `q_bank`, `q_ras_n`, `q_cas_n`, `q_we_n`, `q_cke` and `q_odt` keep their values from before the access.
- R9: For the cycle after a non-access cycle, every `q_*` output equals the corresponding input sampled at that edge.
- R10: A synchronous active-high `rst` sets all configuration words to zero, `err_n`, `q_cs_n` and the `q_` strobes high, and `q_addr`, `q_bank`, `q_cke` and `q_odt` to zero.
- R11: `err_n` is high in the cycle after any cycle that is not an access with bad parity, including non-access cycles with odd parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| quad_mode | input | 1 | Selects the four-select access patterns |
| cs_n | input | 4 | Chip selects, active low |
| addr | input | 16 | Address |
| bank | input | 3 | Bank address |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable |
| cke | input | 2 | Clock enables |
| odt | input | 2 | On-die termination controls |
| par_in | input | 1 | Parity bit making the command word even |
| q_cs_n | output | 4 | Registered chip selects |
| q_addr | output | 16 | Registered address |
| q_bank | output | 3 | Registered bank address |
| q_ras_n | output | 1 | Registered row strobe |
| q_cas_n | output | 1 | Registered column strobe |
| q_we_n | output | 1 | Registered write enable |
| q_cke | output | 2 | Registered clock enables |
| q_odt | output | 2 | Registered termination controls |
| cfg_words | output | 64 | Sixteen 4-bit configuration words, word k at bits 4k+3:4k |
| err_n | output | 1 | Parity error flag, active low, one cycle |

## Verification
All results, including the registered command copy, the frozen or forwarded outputs, the configuration word and the error flag, are due exactly one rising edge after the inputs are sampled. The driver applies each stimulus on a falling edge and queues the complete expected output vector for that cycle. The monitor pops one entry 1 ns after each rising edge, so every comparison falls in the single cycle in which that stimulus is visible. Back-to-back stimuli therefore check the frozen-value rule against the immediately preceding command.

// File: rtl/ctlword_pkg.sv
package ctlword_pkg;

  // Default geometry of the command port and configuration store
  localparam int CS_NUM    = 4;
  localparam int ADDR_W    = 16;
  localparam int BANK_W    = 3;
  localparam int CKE_NUM   = 2;
  localparam int ODT_NUM   = 2;
  localparam int CW_BITS   = 4;
  localparam int CW_COUNT  = 16;
  localparam int CW_SEL_W  = $clog2(CW_COUNT);
  // Lowest address bit that must be zero for a write to be accepted
  localparam int ZERO_FLOOR = 5;

  // Classification of a chip-select pattern
  typedef enum logic [1:0] {
    PAT_NONE,
    PAT_PAIR_LOW,
    PAT_PAIR_HIGH,
    PAT_ALL
  } cs_pattern_e;

endpackage

// File: rtl/ctlword_detect.sv
module ctlword_detect
  import ctlword_pkg::*;
#(
  parameter int NCS = CS_NUM
) (
  input  logic           quad_mode,
  input  logic [NCS-1:0] cs_n,
  output logic           access
);

  localparam int CNT_W = $clog2(NCS + 1);

  logic [CNT_W-1:0] n_low;
  cs_pattern_e      pattern;
  logic             three_low;

  // Number of selects driven low
  always_comb begin
    n_low = '0;
    for (int i = 0; i < NCS; i++) begin
      n_low = n_low + {{(CNT_W-1){1'b0}}, ~cs_n[i]};
    end
  end

  // Pattern classification, mode dependent
  always_comb begin
    pattern = PAT_NONE;
    if (!quad_mode) begin
      if (cs_n[1:0] == 2'b00) pattern = PAT_PAIR_LOW;
    end else if (n_low == CNT_W'(NCS)) begin
      pattern = PAT_ALL;
    end else if (cs_n[3:2] == 2'b00 && n_low == CNT_W'(2)) begin
      pattern = PAT_PAIR_HIGH;
    end
  end

  assign access    = (pattern != PAT_NONE);
  assign three_low = quad_mode && (n_low == CNT_W'(NCS - 1));

  // R3: a three-low pattern in quad mode never opens an access
  always_comb begin
    if (three_low) begin
      a_r3_three_rejected: assert (!access)
        else $error("three-select pattern accepted as access");
    end
  end

endmodule

// File: rtl/ctlword_check.sv
module ctlword_check
  import ctlword_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int BW     = BANK_W,
  parameter int NCKE   = CKE_NUM,
  parameter int WBITS  = CW_BITS,
  parameter int SEL_W  = CW_SEL_W,
  parameter int FLOOR  = ZERO_FLOOR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             access,
  input  logic [AW-1:0]    addr,
  input  logic [BW-1:0]    bank,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             par_in,
  input  logic [NCKE-1:0]  cke,
  output logic             par_ok,
  output logic             wr_en,
  output logic [SEL_W-1:0] sel,
  output logic [WBITS-1:0] data,
  output logic             err_n
);

  logic upper_clear;
  logic any_cke;

  // Even parity over the whole command word plus the parity bit
  assign par_ok      = ~^{addr, bank, ras_n, cas_n, we_n, par_in};
  assign upper_clear = (addr[AW-1:FLOOR] == '0);
  assign any_cke     = |cke;
  assign wr_en       = access && par_ok && upper_clear && any_cke;

  // Field positions are fixed by the neighbouring decoders
  assign sel  = {bank[2], addr[2:0]};
  assign data = {bank[1:0], addr[4:3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      err_n <= 1'b1;
    end else begin
      err_n <= !(access && !par_ok);
    end
  end

  // R7: a low error flag always follows an access
  a_r7_err_after_access: assert property (@(posedge clk) disable iff (rst)
    !err_n |-> $past(access));

  // R11: good parity on the previous cycle keeps the flag high
  a_r11_err_high_on_good: assert property (@(posedge clk) disable iff (rst)
    par_ok |=> err_n);

endmodule

// File: rtl/ctlword_bank.sv
module ctlword_bank
  import ctlword_pkg::*;
#(
  parameter int NWORDS = CW_COUNT,
  parameter int WBITS  = CW_BITS,
  parameter int SEL_W  = $clog2(NWORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        sel,
  input  logic [WBITS-1:0]        data,
  output logic [NWORDS*WBITS-1:0] words_flat
);

  logic [WBITS-1:0] mem [NWORDS];

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    logic [WBITS-1:0] word_q;
    logic             hit;

    assign hit = wr_en && (sel == SEL_W'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (hit) begin
        word_q <= data;
      end
    end

    assign mem[k] = word_q;
    assign words_flat[k*WBITS +: WBITS] = word_q;
  end

  // R4: the addressed word holds the written value one cycle later
  a_r4_word_stored: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(sel)] == $past(data));

  // R5: no enable, no change anywhere in the store
  a_r5_store_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(words_flat));

endmodule

// File: rtl/ctlword_cmdreg.sv
module ctlword_cmdreg
  import ctlword_pkg::*;
#(
  parameter int NCS  = CS_NUM,
  parameter int AW   = ADDR_W,
  parameter int BW   = BANK_W,
  parameter int NCKE = CKE_NUM,
  parameter int NODT = ODT_NUM
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            access,
  input  logic [NCS-1:0]  cs_n,
  input  logic [AW-1:0]   addr,
  input  logic [BW-1:0]   bank,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [NCKE-1:0] cke,
  input  logic [NODT-1:0] odt,
  output logic [NCS-1:0]  q_cs_n,
  output logic [AW-1:0]   q_addr,
  output logic [BW-1:0]   q_bank,
  output logic            q_ras_n,
  output logic            q_cas_n,
  output logic            q_we_n,
  output logic [NCKE-1:0] q_cke,
  output logic [NODT-1:0] q_odt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cs_n  <= '1;
      q_addr  <= '0;
      q_bank  <= '0;
      q_ras_n <= 1'b1;
      q_cas_n <= 1'b1;
      q_we_n  <= 1'b1;
      q_cke   <= '0;
      q_odt   <= '0;
    end else if (access) begin
      // Selects forced inactive; everything else keeps its value
      q_cs_n <= '1;
    end else begin
      q_cs_n  <= cs_n;
      q_addr  <= addr;
      q_bank  <= bank;
      q_ras_n <= ras_n;
      q_cas_n <= cas_n;
      q_we_n  <= we_n;
      q_cke   <= cke;
      q_odt   <= odt;
    end
  end

  // R8: selects go high during an access
  a_r8_selects_high: assert property (@(posedge clk) disable iff (rst)
    access |=> (q_cs_n == '1));

  // R8: the remaining registered outputs are frozen
  a_r8_outputs_frozen: assert property (@(posedge clk) disable iff (rst)
    access |=> $stable({q_addr, q_bank, q_ras_n, q_cas_n, q_we_n, q_cke, q_odt}));

  // R9: ordinary cycles are copied through with one cycle of delay
  a_r9_pass_through: assert property (@(posedge clk) disable iff (rst)
    !access |=> (q_cs_n == $past(cs_n)) && (q_addr == $past(addr))
                && (q_bank == $past(bank)) && (q_cke == $past(cke))
                && (q_odt == $past(odt)));

endmodule

// File: rtl/ctlword_dec.sv
module ctlword_dec
  import ctlword_pkg::*;
#(
  parameter int NCS    = CS_NUM,
  parameter int AW     = ADDR_W,
  parameter int BW     = BANK_W,
  parameter int NCKE   = CKE_NUM,
  parameter int NODT   = ODT_NUM,
  parameter int WBITS  = CW_BITS,
  parameter int NWORDS = CW_COUNT,
  parameter int FLOOR  = ZERO_FLOOR
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    quad_mode,
  input  logic [NCS-1:0]          cs_n,
  input  logic [AW-1:0]           addr,
  input  logic [BW-1:0]           bank,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [NCKE-1:0]         cke,
  input  logic [NODT-1:0]         odt,
  input  logic                    par_in,
  output logic [NCS-1:0]          q_cs_n,
  output logic [AW-1:0]           q_addr,
  output logic [BW-1:0]           q_bank,
  output logic                    q_ras_n,
  output logic                    q_cas_n,
  output logic                    q_we_n,
  output logic [NCKE-1:0]         q_cke,
  output logic [NODT-1:0]         q_odt,
  output logic [NWORDS*WBITS-1:0] cfg_words,
  output logic                    err_n
);

  localparam int SEL_W = $clog2(NWORDS);

  logic             access;
  logic             par_ok;
  logic             wr_en;
  logic [SEL_W-1:0] sel;
  logic [WBITS-1:0] data;

  ctlword_detect #(.NCS(NCS)) u_detect (
    .quad_mode (quad_mode),
    .cs_n      (cs_n),
    .access    (access)
  );

  ctlword_check #(
    .AW(AW), .BW(BW), .NCKE(NCKE), .WBITS(WBITS), .SEL_W(SEL_W), .FLOOR(FLOOR)
  ) u_check (
    .clk    (clk),
    .rst    (rst),
    .access (access),
    .addr   (addr),
    .bank   (bank),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .par_in (par_in),
    .cke    (cke),
    .par_ok (par_ok),
    .wr_en  (wr_en),
    .sel    (sel),
    .data   (data),
    .err_n  (err_n)
  );

  ctlword_bank #(.NWORDS(NWORDS), .WBITS(WBITS), .SEL_W(SEL_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .sel        (sel),
    .data       (data),
    .words_flat (cfg_words)
  );

  ctlword_cmdreg #(
    .NCS(NCS), .AW(AW), .BW(BW), .NCKE(NCKE), .NODT(NODT)
  ) u_cmdreg (
    .clk     (clk),
    .rst     (rst),
    .access  (access),
    .cs_n    (cs_n),
    .addr    (addr),
    .bank    (bank),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .cke     (cke),
    .odt     (odt),
    .q_cs_n  (q_cs_n),
    .q_addr  (q_addr),
    .q_bank  (q_bank),
    .q_ras_n (q_ras_n),
    .q_cas_n (q_cas_n),
    .q_we_n  (q_we_n),
    .q_cke   (q_cke),
    .q_odt   (q_odt)
  );

  // R7: a flagged parity error never coincides with a configuration change
  a_r7_no_write_on_error: assert property (@(posedge clk) disable iff (rst)
    !err_n |-> $stable(cfg_words));

  // R5: with every clock enable low the configuration cannot move
  a_r5_cke_gate: assert property (@(posedge clk) disable iff (rst)
    (cke == '0) |=> $stable(cfg_words));

endmodule

// File: tb/ctlword_dec_test.sv
module ctlword_dec_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        quad_mode = 1'b0;
  logic [3:0]  cs_n = 4'hF;
  logic [15:0] addr = '0;
  logic [2:0]  bank = '0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  cke = 2'b11;
  logic [1:0]  odt = 2'b00;
  logic        par_in = 1'b0;

  logic [3:0]  q_cs_n;
  logic [15:0] q_addr;
  logic [2:0]  q_bank;
  logic        q_ras_n, q_cas_n, q_we_n;
  logic [1:0]  q_cke, q_odt;
  logic [63:0] cfg_words;
  logic        err_n;

  ctlword_dec uut (
    .clk(clk), .rst(rst), .quad_mode(quad_mode), .cs_n(cs_n), .addr(addr),
    .bank(bank), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
    .odt(odt), .par_in(par_in), .q_cs_n(q_cs_n), .q_addr(q_addr),
    .q_bank(q_bank), .q_ras_n(q_ras_n), .q_cas_n(q_cas_n), .q_we_n(q_we_n),
    .q_cke(q_cke), .q_odt(q_odt), .cfg_words(cfg_words), .err_n(err_n)
  );

  // 250 MHz
  always #2 clk = ~clk;

  // Reference state built from the requirements
  logic [3:0]  m_cs;
  logic [15:0] m_addr;
  logic [2:0]  m_bank;
  logic        m_ras, m_cas, m_we;
  logic [1:0]  m_cke, m_odt;
  logic [63:0] m_cfg;
  logic        m_err;

  logic [94:0] exp_q[$];
  string       tag_q[$];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  logic [94:0] act_v, exp_v;
  string       cur_tag;

  task automatic step(input bit r, input bit qm, input logic [3:0] c,
                      input logic [15:0] a, input logic [2:0] b,
                      input logic [2:0] st, input logic [1:0] ck,
                      input logic [1:0] od, input bit badpar, input string tag);
    bit acc;
    int idx;
    @(negedge clk);
    rst = r; quad_mode = qm; cs_n = c; addr = a; bank = b;
    {ras_n, cas_n, we_n} = st; cke = ck; odt = od;
    par_in = (^{a, b, st}) ^ badpar;
    if (r) begin
      m_cs = 4'hF; m_addr = '0; m_bank = '0; {m_ras, m_cas, m_we} = 3'b111;
      m_cke = '0; m_odt = '0; m_cfg = '0; m_err = 1'b1;
    end else begin
      acc = qm ? (c == 4'b0000 || c == 4'b0011) : (c[1:0] == 2'b00);
      if (acc) begin
        m_cs  = 4'hF;
        m_err = !badpar;
        if (!badpar && a[15:5] == 11'd0 && ck != 2'b00) begin
          idx = int'({b[2], a[2:0]});
          m_cfg[idx*4 +: 4] = {b[1:0], a[4:3]};
        end
      end else begin
        m_cs = c; m_addr = a; m_bank = b; {m_ras, m_cas, m_we} = st;
        m_cke = ck; m_odt = od; m_err = 1'b1;
      end
    end
    exp_q.push_back({m_cs, m_addr, m_bank, m_ras, m_cas, m_we, m_cke, m_odt, m_cfg, m_err});
    tag_q.push_back(tag);
  endtask

  // Control-word cycle: index and value placed in their fields
  task automatic cw(input bit qm, input logic [3:0] c, input logic [3:0] sel,
                    input logic [3:0] d, input logic [10:0] hi, input logic [1:0] ck,
                    input logic [2:0] st, input logic [1:0] od, input bit bad,
                    input string tag);
    step(1'b0, qm, c, {hi, d[1:0], sel[2:0]}, {sel[3], d[3:2]}, st, ck, od, bad, tag);
  endtask

  // Monitor: one expected item per rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_v   = exp_q.pop_front();
      cur_tag = tag_q.pop_front();
      act_v   = {q_cs_n, q_addr, q_bank, q_ras_n, q_cas_n, q_we_n, q_cke, q_odt,
                 cfg_words, err_n};
      checks++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL %s: got %h expected %h", cur_tag, act_v, exp_v);
      end
    end
  end

  initial begin
    // R10 reset state
    step(1, 0, 4'hF, 16'h0000, 3'b000, 3'b111, 2'b11, 2'b00, 0, "R10");
    step(1, 0, 4'hF, 16'hFFFF, 3'b111, 3'b000, 2'b11, 2'b11, 0, "R10");
    // R9 ordinary commands pass through
    step(0, 0, 4'b1110, 16'h1234, 3'b101, 3'b010, 2'b11, 2'b01, 0, "R9");
    step(0, 0, 4'b0111, 16'hBEEF, 3'b011, 3'b100, 2'b10, 2'b10, 0, "R9");
    // R11 odd parity outside an access raises no error
    step(0, 0, 4'b1101, 16'h00F0, 3'b001, 3'b001, 2'b01, 2'b00, 1, "R11");
    // R1 non-quad access, R8 outputs frozen from previous cycle
    cw(0, 4'b1100, 4'd5,  4'hA, 11'd0, 2'b11, 3'b111, 2'b00, 0, "R1");
    cw(0, 4'b0000, 4'd12, 4'h5, 11'd0, 2'b01, 3'b000, 2'b11, 0, "R8");
    // R4 word placement at both ends
    cw(0, 4'b1100, 4'd0,  4'hF, 11'd0, 2'b10, 3'b101, 2'b00, 0, "R4");
    cw(0, 4'b0100, 4'd15, 4'h3, 11'd0, 2'b11, 3'b011, 2'b01, 0, "R4");
    // R1 non-quad with only selects 2 and 3 low is not an access
    step(0, 0, 4'b0011, 16'h0555, 3'b110, 3'b110, 2'b11, 2'b10, 0, "R1");
    // R5 upper address bit set, then all clock enables low
    cw(0, 4'b1100, 4'd7, 4'h9, 11'h010, 2'b11, 3'b111, 2'b00, 0, "R5");
    cw(0, 4'b1100, 4'd7, 4'h9, 11'd0,   2'b00, 3'b111, 2'b00, 0, "R5");
    cw(0, 4'b1100, 4'd7, 4'h9, 11'h400, 2'b11, 3'b111, 2'b00, 0, "R5");
    // R6 strobe and termination levels do not matter
    cw(0, 4'b1100, 4'd3, 4'h6, 11'd0, 2'b11, 3'b010, 2'b10, 0, "R6");
    cw(0, 4'b1100, 4'd3, 4'h9, 11'd0, 2'b01, 3'b101, 2'b01, 0, "R6");
    // R7 bad parity: error pulse, word unchanged, then recovery
    step(0, 0, 4'b1011, 16'h2222, 3'b010, 3'b011, 2'b11, 2'b01, 0, "R9");
    cw(0, 4'b1100, 4'd5, 4'h0, 11'd0, 2'b11, 3'b111, 2'b00, 1, "R7");
    cw(0, 4'b1100, 4'd5, 4'h1, 11'd0, 2'b11, 3'b110, 2'b00, 1, "R7");
    step(0, 0, 4'b1111, 16'h0001, 3'b000, 3'b111, 2'b11, 2'b00, 0, "R7");
    cw(0, 4'b1100, 4'd5, 4'h2, 11'd0, 2'b11, 3'b110, 2'b00, 0, "R11");
    // R2 quad mode patterns
    cw(1, 4'b0011, 4'd15, 4'hC, 11'd0, 2'b11, 3'b111, 2'b00, 0, "R2");
    cw(1, 4'b0000, 4'd1,  4'h7, 11'd0, 2'b10, 3'b001, 2'b11, 0, "R2");
    cw(1, 4'b1100, 4'd2,  4'hB, 11'd0, 2'b11, 3'b111, 2'b00, 0, "R2");
    cw(1, 4'b0110, 4'd2,  4'hB, 11'd0, 2'b11, 3'b111, 2'b00, 0, "R2");
    // R3 three selects low in quad mode
    cw(1, 4'b0001, 4'd2, 4'hE, 11'd0, 2'b11, 3'b111, 2'b00, 0, "R3");
    cw(1, 4'b1000, 4'd9, 4'hD, 11'd0, 2'b01, 3'b100, 2'b10, 0, "R3");
    cw(1, 4'b0010, 4'd4, 4'h8, 11'd0, 2'b11, 3'b010, 2'b01, 0, "R3");
    // R7 parity error in quad mode
    cw(1, 4'b0011, 4'd15, 4'h1, 11'd0, 2'b11, 3'b111, 2'b00, 1, "R7");
    step(0, 1, 4'b1111, 16'h00AA, 3'b100, 3'b111, 2'b11, 2'b00, 0, "R11");
    // R10 reset after writes clears everything
    step(1, 1, 4'b0000, 16'h0018, 3'b011, 3'b000, 2'b11, 2'b11, 0, "R10");
    step(0, 0, 4'b1110, 16'h4321, 3'b001, 3'b011, 2'b01, 2'b01, 0, "R9");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule